// File: doc/BRIEF.md
# Lowest-Set-Bit Mask Execution Unit

This block is one integer execution slice. It takes a source operand and returns a mask. In the mask, every bit from bit 0 up to and including the lowest set bit of the source is one, and every bit above it is zero. The same arithmetic gives the mask in all cases: subtract one from the source, then XOR the difference with the source. The unit also returns a six-bit status-flag vector, a fault bit and a write-enable for the destination register.

The operation runs at either a 32-bit or a 64-bit width. The width depends on an operand-width bit and on whether the core is in long mode. Some inputs mark the encoding as illegal: a nonzero vector-length field, or a core in one of the legacy execution modes (real or virtual-8086). When the encoding is illegal, the unit raises an invalid-opcode fault and no register write happens.

Operations enter through a valid/ready input and leave through a valid/ready output, with one register stage between them. An operation is accepted on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output stage is empty or being drained in that same cycle, so the unit accepts one operation per cycle with no bubbles. If the consumer holds `out_ready` low while `out_valid` is high, the output stage keeps its whole payload, and `in_ready` stays low until the consumer takes it.

Top module: `lsm_unit`

## Requirements
- R1: For a legal operation, `out_result` equals (source − 1) XOR source, evaluated at the active width. Bit 0 of the result is therefore always one.
- R2: When the source is zero at the active width, the result is all ones at that width and CF (`out_flags[0]`) is 1. For any other source, CF is 0.
- R3: SF (`out_flags[4]`) equals the most significant bit of the result at the active width: bit 63 for 64-bit operation, bit 31 for 32-bit operation.
- R4: For every operation, OF (`out_flags[5]`) and ZF (`out_flags[3]`) are 0. AF (`out_flags[2]`) and PF (`out_flags[1]`) carry no defined value and are driven to 0.
- R5: The operation is 64-bit only when `mode_long` = 1 and `in_wide` = 1. In every other case it is 32-bit: only bits 31:0 of the source take part, and bits 63:32 of the result are 0. Outside long mode, `in_wide` has no effect.
- R6: A nonzero `in_len` raises `out_fault`. A faulting operation drives `out_wr_en` = 0, `out_result` = 0 and `out_flags` = 0.
- R7: When `mode_legacy` = 1, the operation raises `out_fault`, whatever the other inputs are.
- R8: An operation accepted on a clock edge shows up with `out_valid` = 1 after that edge. While `out_valid` = 1 and `out_ready` = 0, every output holds its value. `in_ready` = !`out_valid` || `out_ready`.
- R9: After reset, `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An operation is offered |
| in_ready | output | 1 | The unit can accept an operation |
| in_src | input | 64 | Source operand |
| in_wide | input | 1 | Operand-width bit; 1 requests 64-bit operation |
| in_len | input | 1 | Vector-length field; must be 0 for a legal operation |
| mode_long | input | 1 | The core is in 64-bit long mode |
| mode_legacy | input | 1 | The core is in real or virtual-8086 mode |
| out_valid | output | 1 | A result is presented |
| out_ready | input | 1 | The consumer takes the result |
| out_result | output | 64 | Mask result |
| out_flags | output | 6 | Flags {OF, SF, ZF, AF, PF, CF}, OF in bit 5 |
| out_fault | output | 1 | Invalid-opcode fault |
| out_wr_en | output | 1 | The destination register may be written |

## Verification
The hardest situation to reach from the ports is an output held under back-pressure while a corner-case operand is waiting: for example, a zero source in 32-bit mode with nonzero upper bits, or a faulting operation. This has to happen while a new operation, of a different width and mode, is offered at the input. The stimulus reaches this state by driving `out_ready` randomly low in about three cycles out of ten, during both a directed corner list and a long random run. In both, mode, width and length bits change from one operation to the next. The bench records each held payload and checks that it comes back unchanged on the next cycle.

// File: rtl/lsm_pkg.sv
package lsm_pkg;
  localparam int unsigned FLAG_W = 6;

  typedef struct packed {
    logic of;
    logic sf;
    logic zf;
    logic af;
    logic pf;
    logic cf;
  } flags_t;
endpackage

// File: rtl/lsm_decode.sv
module lsm_decode #(
  parameter int unsigned LW = 1
) (
  input  logic          mode_long,
  input  logic          mode_legacy,
  input  logic          op_wide,
  input  logic [LW-1:0] op_len,
  output logic          use_wide,
  output logic          fault
);
  // The width bit only counts in long mode.
  assign use_wide = mode_long & op_wide;
  assign fault    = mode_legacy | (|op_len);
endmodule

// File: rtl/lsm_core.sv
module lsm_core
  import lsm_pkg::*;
#(
  parameter int unsigned XLEN   = 64,
  parameter int unsigned NARROW = 32
) (
  input  logic [XLEN-1:0] src,
  input  logic            use_wide,
  input  logic            kill,
  output logic [XLEN-1:0] mask,
  output flags_t          flags
);
  localparam logic [XLEN-1:0] NARROW_KEEP = {{(XLEN-NARROW){1'b0}}, {NARROW{1'b1}}};
  localparam logic [XLEN-1:0] ONE         = {{(XLEN-1){1'b0}}, 1'b1};

  logic [XLEN-1:0] src_eff;
  logic [XLEN-1:0] dec;
  logic [XLEN-1:0] raw;
  logic [XLEN-1:0] sized;
  logic            top_bit;
  logic            src_zero;

  assign src_eff  = use_wide ? src : (src & NARROW_KEEP);
  assign dec      = src_eff - ONE;
  assign raw      = dec ^ src_eff;
  assign sized    = use_wide ? raw : (raw & NARROW_KEEP);
  assign top_bit  = use_wide ? sized[XLEN-1] : sized[NARROW-1];
  assign src_zero = ~|src_eff;

  always_comb begin
    flags = '0;
    mask  = '0;
    if (!kill) begin
      mask     = sized;
      flags.sf = top_bit;
      flags.cf = src_zero;
    end
  end
endmodule

// File: rtl/lsm_outreg.sv
module lsm_outreg #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  logic         vld_q;
  logic [W-1:0] data_q;

  assign in_ready  = !vld_q || out_ready;
  assign out_valid = vld_q;
  assign out_data  = data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      data_q <= '0;
    end else if (in_ready) begin
      vld_q <= in_valid;
      if (in_valid) data_q <= in_data;
    end
  end
endmodule

// File: rtl/lsm_unit.sv
module lsm_unit
  import lsm_pkg::*;
#(
  parameter int unsigned XLEN   = 64,
  parameter int unsigned NARROW = 32,
  parameter int unsigned LW     = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [XLEN-1:0]   in_src,
  input  logic              in_wide,
  input  logic [LW-1:0]     in_len,
  input  logic              mode_long,
  input  logic              mode_legacy,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [XLEN-1:0]   out_result,
  output logic [FLAG_W-1:0] out_flags,
  output logic              out_fault,
  output logic              out_wr_en
);
  localparam int unsigned PW = XLEN + FLAG_W + 2;

  logic            use_wide;
  logic            fault;
  logic [XLEN-1:0] mask;
  flags_t          flags;
  logic [PW-1:0]   pay_in;
  logic [PW-1:0]   pay_out;

  lsm_decode #(.LW(LW)) u_dec (
    .mode_long   (mode_long),
    .mode_legacy (mode_legacy),
    .op_wide     (in_wide),
    .op_len      (in_len),
    .use_wide    (use_wide),
    .fault       (fault)
  );

  lsm_core #(.XLEN(XLEN), .NARROW(NARROW)) u_core (
    .src      (in_src),
    .use_wide (use_wide),
    .kill     (fault),
    .mask     (mask),
    .flags    (flags)
  );

  assign pay_in = {mask, flags, fault, !fault};

  lsm_outreg #(.W(PW)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (pay_in),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (pay_out)
  );

  assign out_result = pay_out[PW-1 -: XLEN];
  assign out_flags  = pay_out[FLAG_W+1 -: FLAG_W];
  assign out_fault  = pay_out[1];
  assign out_wr_en  = pay_out[0];
endmodule

// File: rtl/lsm_unit_chk.sv
module lsm_unit_chk #(
  parameter int unsigned XLEN   = 64,
  parameter int unsigned NARROW = 32,
  parameter int unsigned LW     = 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_ready,
  input logic            in_wide,
  input logic [LW-1:0]   in_len,
  input logic            mode_long,
  input logic            mode_legacy,
  input logic            out_valid,
  input logic            out_ready,
  input logic [XLEN-1:0] out_result,
  input logic [5:0]      out_flags,
  input logic            out_fault,
  input logic            out_wr_en
);
  logic narrow_q;
  logic legacy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      narrow_q <= 1'b0;
      legacy_q <= 1'b0;
    end else if (in_valid && in_ready) begin
      narrow_q <= !(mode_long && in_wide);
      legacy_q <= mode_legacy;
    end
  end

  AST_BIT0_SET: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_fault |-> out_result[0]); // R1
  AST_CF_ALL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_flags[0] |-> &out_result[NARROW-1:0]); // R2
  AST_ZF_OF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !out_flags[5] && !out_flags[3]); // R4
  AST_NARROW_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && narrow_q |-> out_result[XLEN-1:NARROW] == '0); // R5
  AST_FAULT_NOWRITE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_fault |-> !out_wr_en && out_result == '0); // R6
  AST_LEGACY_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && legacy_q |-> out_fault); // R7
  AST_ACCEPT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid); // R8
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_result) && $stable(out_flags)
      && $stable(out_fault) && $stable(out_wr_en)); // R8
endmodule

bind lsm_unit lsm_unit_chk #(.XLEN(XLEN), .NARROW(NARROW), .LW(LW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .in_wide     (in_wide),
  .in_len      (in_len),
  .mode_long   (mode_long),
  .mode_legacy (mode_legacy),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_result  (out_result),
  .out_flags   (out_flags),
  .out_fault   (out_fault),
  .out_wr_en   (out_wr_en)
);

// File: tb/lsm_unit_bench.sv
`timescale 1ns/1ps
module lsm_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_src = '0;
  logic        in_wide = 1'b0;
  logic [0:0]  in_len = '0;
  logic        mode_long = 1'b0;
  logic        mode_legacy = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [63:0] out_result;
  logic [5:0]  out_flags;
  logic        out_fault;
  logic        out_wr_en;

  typedef struct packed {
    logic [63:0] res;
    logic [5:0]  fl;
    logic        fault;
    logic        wen;
    logic        narrow;
    logic        zero;
  } exp_t;

  exp_t        expq[$];
  int          total = 0;
  int          bad = 0;
  bit          done = 0;
  bit          held_pend = 0;
  logic [63:0] held_res;
  logic [5:0]  held_fl;

  always #10 clk = ~clk;

  lsm_unit u_lsm_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_src(in_src), .in_wide(in_wide), .in_len(in_len),
    .mode_long(mode_long), .mode_legacy(mode_legacy),
    .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result),
    .out_flags(out_flags), .out_fault(out_fault), .out_wr_en(out_wr_en)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Behavioural model: scan for the lowest one and fill up to it.
  function automatic exp_t model(input logic [63:0] src, input bit lng, input bit wide,
                                 input bit leg, input bit len);
    exp_t e;
    int w;
    int low;
    e = '0;
    w = (lng && wide) ? 64 : 32;
    e.narrow = (w == 32);
    if (leg || len) begin
      e.fault = 1'b1;
      return e;
    end
    e.wen = 1'b1;
    low = -1;
    for (int i = 0; i < w; i++) if (src[i] && low < 0) low = i;
    if (low < 0) begin
      for (int i = 0; i < w; i++) e.res[i] = 1'b1;
      e.fl[0] = 1'b1;
      e.zero = 1'b1;
    end else begin
      for (int i = 0; i <= low; i++) e.res[i] = 1'b1;
    end
    e.fl[4] = e.res[w-1];
    return e;
  endfunction

  // Called 1 ns after a falling edge: inputs and outputs are settled for the coming edge.
  task automatic monitor();
    exp_t e;
    if (held_pend) begin
      chk("R8 held valid", {63'b0, out_valid}, 64'd1);
      chk("R8 held result", out_result, held_res);
      chk("R8 held flags", {58'b0, out_flags}, {58'b0, held_fl});
    end
    if (expq.size() != 0) chk("R8 pending shown", {63'b0, out_valid}, 64'd1);
    chk("R8 ready rule", {63'b0, in_ready}, {63'b0, !out_valid || out_ready});
    if (out_valid && out_ready) begin
      if (expq.size() == 0) begin
        chk("R8 unexpected output", 64'd1, 64'd0);
      end else begin
        e = expq.pop_front();
        chk(e.zero ? "R2 result" : (e.narrow ? "R5 result" : "R1 result"), out_result, e.res);
        chk("R2 CF", {63'b0, out_flags[0]}, {63'b0, e.fl[0]});
        chk("R3 SF", {63'b0, out_flags[4]}, {63'b0, e.fl[4]});
        chk("R4 OF ZF", {62'b0, out_flags[5], out_flags[3]}, 64'd0);
        chk("R6 R7 fault", {63'b0, out_fault}, {63'b0, e.fault});
        chk("R6 write enable", {63'b0, out_wr_en}, {63'b0, e.wen});
      end
    end
    held_pend = out_valid && !out_ready;
    held_res  = out_result;
    held_fl   = out_flags;
  endtask

  task automatic send(input logic [63:0] src, input bit lng, input bit wide,
                      input bit leg, input bit len);
    bit took;
    took = 0;
    while (!took) begin
      @(negedge clk);
      in_valid = 1'b1; in_src = src; in_wide = wide; in_len = len;
      mode_long = lng; mode_legacy = leg;
      out_ready = ($urandom % 10) < 7;
      #1;
      monitor();
      if (in_ready) begin
        expq.push_back(model(src, lng, wide, leg, len));
        took = 1;
      end
    end
  endtask

  task automatic idle(input bit drain);
    @(negedge clk);
    in_valid = 1'b0;
    in_src = {$urandom, $urandom};
    out_ready = drain ? 1'b1 : (($urandom % 10) < 7);
    #1;
    monitor();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R9 reset out_valid", {63'b0, out_valid}, 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R9 after reset out_valid", {63'b0, out_valid}, 64'd0);
    // R2 zero source at both widths
    send(64'd0, 1, 1, 0, 0);
    send(64'd0, 1, 0, 0, 0);
    // R5 narrow with only upper bits set behaves as zero
    send(64'hF000_0000_0000_0000, 1, 0, 0, 0);
    // R1 all ones, bit 0 set
    send(64'hFFFF_FFFF_FFFF_FFFF, 1, 1, 0, 0);
    send(64'h0000_0000_0000_0001, 1, 1, 0, 0);
    // R3 single top bit at each width
    send(64'h8000_0000_0000_0000, 1, 1, 0, 0);
    send(64'h0000_0000_8000_0000, 1, 0, 0, 0);
    send(64'h0000_0000_8000_0000, 1, 1, 0, 0);
    // R5 width bit ignored outside long mode
    send(64'h8000_0000_0000_0000, 0, 1, 0, 0);
    send(64'hABCD_0000_0000_0100, 0, 1, 0, 0);
    // R6 length field, R7 legacy mode
    send(64'h0000_0000_0000_0010, 1, 1, 0, 1);
    send(64'h0000_0000_0000_0000, 0, 0, 1, 0);
    send(64'h1234_5678_9ABC_DEF0, 1, 1, 1, 1);
    for (int n = 0; n < 3000; n++) begin
      logic [63:0] s;
      s = {$urandom, $urandom};
      case ($urandom % 8)
        0: s = 64'd1 << ($urandom % 64);
        1: s = s & 64'hFFFF_FFFF_0000_0000;
        default: ;
      endcase
      send(s, ($urandom % 4) != 0, $urandom % 2, ($urandom % 16) == 0, ($urandom % 16) == 0);
      if (($urandom % 5) == 0) idle(0);
    end
    for (int n = 0; n < 8; n++) idle(1);
    chk("R8 queue drained", 64'(expq.size()), 64'd0);
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      done = 1;
      bad++;
      total++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule